// File: doc/BRIEF.md
# System Control Register Window

This block is a 4 KB window of 32-bit system control words for a multicore chip. A simple register bus reaches it. The bus gives a valid strobe, a write flag, a word index, and write data. Every word of the window holds whatever is last written to it. A read returns the stored word one cycle after the strobe, together with a read-valid flag.

Two kinds of word behave differently from plain storage. A single control word turns certain written values into one-cycle request pulses for system reset or for shutdown. Three identification words always read back with two status bits forced high. Four identification words take fixed values on reset, and every other word reads as zero after reset.

The reset and power sequencing that act on the request pulses sit outside this block.

Top module: `sysctl_regwin`

## Requirements
- R1: A read strobe (bus_valid=1, bus_write=0) on word index N makes bus_rvalid go high one cycle later. bus_rdata then carries the last value written to word N, with only the forcing of R7 applied.
- R2: After reset, word 0x40 reads as 0x05F20121, word 0x41 as 0x00000002, word 0x42 as 0x05F30121 and word 0x43 as 0x05F40121, before the forcing of R7. Every other word reads as zero. This holds whatever was written before the reset.
- R3: A write of 1 or 2 to the control word (index 0x3C0, byte offset 0xF00) raises reset_req for exactly one cycle, registered on the edge that accepts the write.
- R4: A write of 3 to the control word raises shutdown_req for exactly one cycle, registered on the edge that accepts the write.
- R5: A write of any other value to the control word, or a write of any value to any other word, raises neither request. reset_req and shutdown_req are never high together.
- R6: The control word stores the written value like any other word, whether or not the write raised a request.
- R7: Reads of word indices 0x40, 0x42 and 0x43 (byte offsets 0x100, 0x108, 0x10C) return the stored value ORed with 0x30000000. The stored value is not altered by this. No other word has bits forced.
- R8: bus_rvalid is high only in the cycle after a read strobe. A write or an idle cycle gives no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 10 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, meaningful while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response valid |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The assertions take for granted that the bus offers at most one access per cycle. They also assume that every input is stable and known around the clock edge whenever bus_valid is high. No check is made on the write data of read strobes.

The stimulus drives every access at the falling edge and holds it for one full cycle, then drops the strobe before the next access. Consecutive accesses still occur back to back, because the next access can be driven in the same instant as the drop.

Reset is applied only with bus_valid low. This keeps the request and read-valid history behind the past-value checks clean.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // word indices with fixed reset contents
  localparam int unsigned ID_WORD_A  = 32'h40;
  localparam int unsigned ID_WORD_B  = 32'h41;
  localparam int unsigned ID_WORD_C  = 32'h42;
  localparam int unsigned ID_WORD_D  = 32'h43;

  // control word decoding requests
  localparam int unsigned CTRL_WORD  = 32'h3C0;

  // forced status bits on identification reads
  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;

  typedef enum logic [1:0] {
    REQ_NONE     = 2'd0,
    REQ_RESET    = 2'd1,
    REQ_SHUTDOWN = 2'd2
  } req_kind_e;

  // reset contents of a word, as read before forcing
  function automatic logic [31:0] word_default(input int unsigned idx);
    case (idx)
      ID_WORD_A: word_default = 32'h05F2_0121;
      ID_WORD_B: word_default = 32'h0000_0002;
      ID_WORD_C: word_default = 32'h05F3_0121;
      ID_WORD_D: word_default = 32'h05F4_0121;
      default:   word_default = 32'h0000_0000;
    endcase
  endfunction

  // decode of a value written to the control word
  function automatic req_kind_e ctrl_decode(input logic [31:0] value);
    if (value == 32'd1 || value == 32'd2) begin
      ctrl_decode = REQ_RESET;
    end else if (value == 32'd3) begin
      ctrl_decode = REQ_SHUTDOWN;
    end else begin
      ctrl_decode = REQ_NONE;
    end
  endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [WORD_W-1:0] rd_idx
);

  localparam int WORDS = 1 << WORD_W;

  // plain array, no reset: maps onto block RAM
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] mem_q;

  // one flag per word: set once written since reset
  logic [WORDS-1:0]  touched;
  logic              touched_q;
  logic [WORD_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wdata;
    end
    if (rd_en) begin
      mem_q <= mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched <= '0;
    end else if (wr_en) begin
      touched[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched_q <= 1'b0;
      idx_q     <= '0;
    end else if (rd_en) begin
      touched_q <= touched[idx];
      idx_q     <= idx;
    end
  end

  // words never written since reset show their reset contents
  always_comb begin
    if (touched_q) begin
      rd_data = mem_q;
    end else begin
      rd_data = DATA_W'(word_default(int'(idx_q)));
    end
  end

  assign rd_idx = idx_q;

endmodule

// File: rtl/sysctl_req_gen.sv
module sysctl_req_gen
  import sysctl_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              reset_req,
  output logic              shutdown_req
);

  localparam logic [WORD_W-1:0] CTRL_IDX = WORD_W'(CTRL_WORD);

  req_kind_e kind;

  always_comb begin
    kind = REQ_NONE;
    if (wr_en && idx == CTRL_IDX) begin
      kind = ctrl_decode(32'(wdata));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= (kind == REQ_RESET);
      shutdown_req <= (kind == REQ_SHUTDOWN);
    end
  end

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reset_req, shutdown_req}));

endmodule

// File: rtl/sysctl_read_fmt.sv
module sysctl_read_fmt
  import sysctl_pkg::*;
#(
  parameter int          WORD_W    = 10,
  parameter int          DATA_W    = 32,
  parameter int          NFORCE    = 3,
  parameter int unsigned FORCE_IDX [NFORCE] = '{32'h40, 32'h42, 32'h43}
) (
  input  logic [WORD_W-1:0] idx,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] data
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(FORCE_MASK);

  logic [NFORCE-1:0] hit;

  for (genvar g = 0; g < NFORCE; g++) begin : g_force
    assign hit[g] = (idx == WORD_W'(FORCE_IDX[g]));
  end

  assign data = (|hit) ? (raw | MASK) : raw;

endmodule

// File: rtl/sysctl_regwin.sv
module sysctl_regwin
  import sysctl_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [WORD_W-1:0] bus_word_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              reset_req,
  output logic              shutdown_req
);

  localparam logic [WORD_W-1:0] CTRL_IDX = WORD_W'(CTRL_WORD);
  localparam logic [DATA_W-1:0] MASK     = DATA_W'(FORCE_MASK);

  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] raw_data;
  logic [WORD_W-1:0] raw_idx;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  sysctl_store #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .idx     (bus_word_addr),
    .wdata   (bus_wdata),
    .rd_data (raw_data),
    .rd_idx  (raw_idx)
  );

  sysctl_read_fmt #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_fmt (
    .idx  (raw_idx),
    .raw  (raw_data),
    .data (bus_rdata)
  );

  sysctl_req_gen #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_req (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .idx          (bus_word_addr),
    .wdata        (bus_wdata),
    .reset_req    (reset_req),
    .shutdown_req (shutdown_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
    end
  end

  // R8
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write));

  // R3
  reset_src_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(bus_valid && bus_write && bus_word_addr == CTRL_IDX &&
                        (bus_wdata == DATA_W'(1) || bus_wdata == DATA_W'(2))));

  // R4
  shutdown_src_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(bus_valid && bus_write && bus_word_addr == CTRL_IDX &&
                           bus_wdata == DATA_W'(3)));

  // R7
  force_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && (raw_idx == WORD_W'(ID_WORD_A) || raw_idx == WORD_W'(ID_WORD_C) ||
                    raw_idx == WORD_W'(ID_WORD_D)))
      |-> ((bus_rdata & MASK) == MASK));

endmodule

// File: tb/sysctl_regwin_bench.sv
module sysctl_regwin_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_word_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        reset_req;
  logic        shutdown_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  sysctl_regwin u_sysctl_regwin (
    .clk           (clk),
    .rst           (rst),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_word_addr (bus_word_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .reset_req     (reset_req),
    .shutdown_req  (shutdown_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: compares each read response against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  // driver: one access per cycle, starting just after a falling edge
  task automatic op(input logic w, input logic [9:0] a, input logic [31:0] d,
                    input logic [31:0] exp, input string tag);
    logic er, es;
    er = w && a == 10'h3C0 && (d == 32'd1 || d == 32'd2);
    es = w && a == 10'h3C0 && d == 32'd3;
    bus_valid     = 1'b1;
    bus_write     = w;
    bus_word_addr = a;
    bus_wdata     = d;
    if (!w) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    chk({tag, " reset_req"}, 32'(reset_req), 32'(er));
    chk({tag, " shutdown_req"}, 32'(shutdown_req), 32'(es));
    chk({"R8 rvalid after ", tag}, 32'(bus_rvalid), 32'(!w));
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    op(1'b1, a, d, 32'd0, tag);
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    op(1'b0, a, 32'd0, exp, tag);
  endtask

  task automatic idle(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " idle reset_req"}, 32'(reset_req), 32'd0);
    chk({tag, " idle shutdown_req"}, 32'(shutdown_req), 32'd0);
  endtask

  task automatic do_reset();
    rst       = 1'b1;
    bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 rvalid in reset", 32'(bus_rvalid), 32'd0);
    chk("R5 reset_req in reset", 32'(reset_req), 32'd0);
    chk("R5 shutdown_req in reset", 32'(shutdown_req), 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    do_reset();

    // reset contents and forced bits
    rd(10'h040, 32'h35F2_0121, "R2 R7 word 40 default");
    rd(10'h041, 32'h0000_0002, "R2 word 41 default unforced");
    rd(10'h042, 32'h35F3_0121, "R2 R7 word 42 default");
    rd(10'h043, 32'h35F4_0121, "R2 R7 word 43 default");
    rd(10'h000, 32'h0,         "R2 word 0 zero");
    rd(10'h3C0, 32'h0,         "R2 control word zero");
    rd(10'h3FF, 32'h0,         "R2 top word zero");

    // plain storage
    wr(10'h010, 32'hDEAD_BEEF, "R1 write 10");
    rd(10'h010, 32'hDEAD_BEEF, "R1 read 10");
    wr(10'h3FF, 32'h1234_5678, "R1 write 3FF");
    wr(10'h011, 32'hA5A5_0F0F, "R1 write 11");
    rd(10'h3FF, 32'h1234_5678, "R1 read 3FF");
    rd(10'h011, 32'hA5A5_0F0F, "R1 read 11");

    // forcing leaves storage untouched
    wr(10'h040, 32'h0000_0000, "R7 write 40");
    rd(10'h040, 32'h3000_0000, "R7 read 40 forced");
    wr(10'h041, 32'hFFFF_0000, "R7 write 41");
    rd(10'h041, 32'hFFFF_0000, "R7 read 41 unforced");
    wr(10'h042, 32'h3000_0005, "R7 write 42");
    rd(10'h042, 32'h3000_0005, "R7 read 42 already set");
    wr(10'h043, 32'h0000_00C3, "R7 write 43");
    rd(10'h043, 32'h3000_00C3, "R7 read 43 forced");
    wr(10'h044, 32'h0000_0001, "R7 write 44");
    rd(10'h044, 32'h0000_0001, "R7 read 44 unforced");

    // control word requests
    wr(10'h3C0, 32'd1, "R3 value 1");
    idle("R3 pulse ends");
    wr(10'h3C0, 32'd2, "R3 value 2");
    idle("R3 pulse ends");
    rd(10'h3C0, 32'd2, "R6 stored 2");
    wr(10'h3C0, 32'd3, "R4 value 3");
    idle("R4 pulse ends");
    rd(10'h3C0, 32'd3, "R6 stored 3");
    wr(10'h3C0, 32'd0, "R5 value 0");
    wr(10'h3C0, 32'd4, "R5 value 4");
    rd(10'h3C0, 32'd4, "R6 stored 4");
    wr(10'h3C1, 32'd1, "R5 other word value 1");
    wr(10'h3BF, 32'd3, "R5 other word value 3");
    wr(10'h3C0, 32'h0000_0101, "R5 value 101");
    wr(10'h3C0, 32'd1, "R3 back to back first");
    wr(10'h3C0, 32'd3, "R4 back to back second");
    idle("R5 after back to back");

    // reset restores contents regardless of writes
    do_reset();
    rd(10'h010, 32'h0,         "R2 word 10 after reset");
    rd(10'h040, 32'h35F2_0121, "R2 word 40 after reset");
    rd(10'h041, 32'h0000_0002, "R2 word 41 after reset");
    rd(10'h3C0, 32'h0,         "R2 control after reset");
    idle("drain");
    chk("R8 responses outstanding", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule